// File: doc/BRIEF.md
# Gated Programmable Clock Divider

This block derives a slower clock from a fast reference clock by an integer ratio chosen through a small register interface, and adds a clock-enable gate in front of the output. Software selects the ratio by writing a short code into a divisor register. It turns the output on or off through one bit of an enable register. A parameter fixes the code width at 5 bits, or at 6 bits with a large-ratio mode for slow peripheral clocks.

A new ratio is not applied at once. The block first finishes the current output period. Until the new ratio is in place and has settled, it raises two busy flags in a shared status register. Software polls these flags before and after each divisor write. Ratio and gate changes are applied only while the output is low, so the output never carries a shortened pulse.

Top module: `clkdiv_gated`

## Requirements
- R1: Registers are selected by `reg_addr`: 0 is status (read only), 1 is enable, 2 is divisor. The enable bit sits at position GATE_BIT (default 0), and all other enable-register bits read 0. The divisor register reads back the last code written, zero-extended. After reset all three registers read 0 and the output is low.
- R2: In either width, a code from 1 to 31 (with bit 5 clear in the 6-bit mode) divides the reference by that value.
- R3: Code 0 selects the largest plain ratio: 32 in the 5-bit mode and 64 in the 6-bit mode.
- R4: In the 6-bit mode, a code with bit 5 set and a low-5-bit value n divides by 64·n. When n is 0 it divides by 64.
- R5: For a ratio D of 2 or more, each output period starts with a high phase of floor(D/2) reference cycles, followed by a low phase of D−floor(D/2) cycles.
- R6: With a ratio of 1 and the gate on, the output follows the reference clock: high in its high phase and low in its low phase.
- R7: Status bits 3 and 4 both read 1 from the cycle after a divisor write. When the output is stopped, the new ratio is applied on the next cycle. When it is running, the ratio is applied at the next period boundary. The busy bits then stay set for 2 more reference cycles.
- R8: A new ratio is applied only at a period boundary while the output is low. The first period after the change already has the new length.
- R9: A gate change takes effect only while the output is low. Clearing the gate lets the current high phase finish at full length, and the output then stays low.
- R10: A divisor write made while busy is set is accepted. The last code written is the one applied once the pending update completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe, one reference cycle per write |
| reg_addr | input | 2 | Register select: 0 status, 1 enable, 2 divisor |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data of the selected register (combinational) |
| clk_div_o | output | 1 | Divided, gated output clock |

## Verification
Assertions check on every cycle that a ratio or gate change never lands while the output is high, that no new ratio is taken during the settle window, that every rising edge of the output begins a fresh count, and that busy follows a divisor write. Only the bench scenarios can show the numeric behaviour. These are the period and high time produced by each code in both widths, including the zero code and the large-ratio codes. They also cover the exact busy duration when stopped and when running, last-write-wins on writes made while busy, the full-length final pulse after the gate is cleared, and pass-through at a ratio of 1.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;

  // widest ratio: 64 * 31 = 1984 needs 11 bits
  localparam int unsigned RATIO_W = 11;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_GATE   = 2'd1,
    SEL_RATIO  = 2'd2
  } reg_sel_e;

  // code -> division ratio; wide selects the 6-bit field with large-ratio mode
  function automatic logic [RATIO_W-1:0] code_to_ratio(input logic [5:0] code,
                                                        input logic       wide);
    logic [RATIO_W-1:0] r;
    if (wide && code[5]) begin
      r = (code[4:0] == 5'd0) ? RATIO_W'(64) : RATIO_W'({code[4:0], 6'd0});
    end else if (code[4:0] == 5'd0) begin
      r = wide ? RATIO_W'(64) : RATIO_W'(32);
    end else begin
      r = RATIO_W'(code[4:0]);
    end
    return r;
  endfunction

endpackage

// File: rtl/clkdiv_regs.sv
`timescale 1ns/1ps
module clkdiv_regs #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned CODE_W   = 5,
  parameter int unsigned GATE_BIT = 0,
  parameter int unsigned BUSY_LO  = 3,
  parameter int unsigned BUSY_HI  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              take,
  input  logic              settling,
  output logic              pend,
  output logic [CODE_W-1:0] code,
  output logic              gate_req
);
  import clkdiv_pkg::*;

  logic pend_q, pend_d;
  logic [CODE_W-1:0] code_q;
  logic gate_q;
  logic ratio_wr, gate_wr, busy;
  logic unused_wdata;

  assign ratio_wr     = wr_en && (addr == SEL_RATIO);
  assign gate_wr      = wr_en && (addr == SEL_GATE);
  assign busy         = pend_q || settling;
  assign unused_wdata = ^wdata;

  always_comb begin
    pend_d = pend_q;
    if (take)     pend_d = 1'b0;
    if (ratio_wr) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      code_q <= '0;
      gate_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      if (ratio_wr) code_q <= wdata[CODE_W-1:0];
      if (gate_wr)  gate_q <= wdata[GATE_BIT];
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      SEL_STATUS: begin
        rdata[BUSY_LO] = busy;
        rdata[BUSY_HI] = busy;
      end
      SEL_GATE:  rdata[GATE_BIT] = gate_q;
      SEL_RATIO: rdata[CODE_W-1:0] = code_q;
      default:   rdata = '0;
    endcase
  end

  assign pend     = pend_q;
  assign code     = code_q;
  assign gate_req = gate_q;

  // R7: busy is raised in the cycle after a divisor write
  p_busy_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_wr |=> pend_q);

endmodule

// File: rtl/clkdiv_core.sv
`timescale 1ns/1ps
module clkdiv_core #(
  parameter int unsigned CODE_W = 5,
  parameter bit          WIDE   = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pend,
  input  logic [CODE_W-1:0] code,
  input  logic              gate_req,
  output logic              take,
  output logic              settling,
  output logic              div_out,
  output logic              pass_en
);
  import clkdiv_pkg::*;

  localparam logic [RATIO_W-1:0] ONE = RATIO_W'(1);
  localparam int unsigned SETTLE = 2;

  logic [RATIO_W-1:0] cnt_q, cnt_d, ratio_q, ratio_d;
  logic run_q, run_d, out_q, out_d, pass_q;
  logic [1:0] settle_q, settle_d;
  logic at_edge;

  always_comb begin
    at_edge  = !run_q || (cnt_q == ratio_q - ONE);
    take     = pend && (settle_q == 2'd0) && at_edge;
    ratio_d  = take ? code_to_ratio(6'(code), WIDE) : ratio_q;
    run_d    = at_edge ? gate_req : run_q;
    cnt_d    = (!run_d || at_edge) ? '0 : cnt_q + ONE;
    out_d    = run_d && (cnt_d < (ratio_d >> 1));
    if (take)                   settle_d = 2'(SETTLE);
    else if (settle_q != 2'd0)  settle_d = settle_q - 2'd1;
    else                        settle_d = 2'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      ratio_q  <= code_to_ratio(6'd0, WIDE);
      run_q    <= 1'b0;
      out_q    <= 1'b0;
      settle_q <= 2'd0;
    end else begin
      cnt_q    <= cnt_d;
      ratio_q  <= ratio_d;
      run_q    <= run_d;
      out_q    <= out_d;
      settle_q <= settle_d;
    end
  end

  // pass-through enable moves only while the reference is low
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) pass_q <= 1'b0;
    else        pass_q <= run_q && (ratio_q == ONE);
  end

  assign settling = (settle_q != 2'd0);
  assign div_out  = out_q;
  assign pass_en  = pass_q;

  // R8: a new ratio lands only after a low output cycle
  p_ratio_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_q != $past(ratio_q)) |-> !$past(out_q));

  // R9: gate start or stop lands only after a low output cycle
  p_gate_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(run_q) || $fell(run_q)) |-> !$past(out_q));

  // R7: no new ratio is taken while the settle window runs
  p_settle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (settle_q != 2'd0) |=> $stable(ratio_q));

  // R5: every output rise starts a fresh period count
  p_rise_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_q) |-> (cnt_q == '0));

endmodule

// File: rtl/clkdiv_gated.sv
`timescale 1ns/1ps
module clkdiv_gated #(
  parameter int unsigned DATA_W    = 8,
  parameter bit          WIDE_MODE = 1'b0,
  parameter int unsigned GATE_BIT  = 0
) (
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              clk_div_o
);
  localparam int unsigned CODE_W = WIDE_MODE ? 6 : 5;

  logic [1:0] rst_sync_q;
  logic rst_s_n;
  logic take, settling, pend, gate_req, div_out, pass_en;
  logic [CODE_W-1:0] code;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  clkdiv_regs #(
    .DATA_W(DATA_W), .CODE_W(CODE_W), .GATE_BIT(GATE_BIT),
    .BUSY_LO(3), .BUSY_HI(4)
  ) u_regs (
    .clk(clk_ref), .rst_n(rst_s_n), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .take(take), .settling(settling),
    .pend(pend), .code(code), .gate_req(gate_req)
  );

  clkdiv_core #(
    .CODE_W(CODE_W), .WIDE(WIDE_MODE)
  ) u_core (
    .clk(clk_ref), .rst_n(rst_s_n), .pend(pend), .code(code),
    .gate_req(gate_req), .take(take), .settling(settling),
    .div_out(div_out), .pass_en(pass_en)
  );

  assign clk_div_o = div_out | (clk_ref & pass_en);

endmodule

// File: tb/test_clkdiv_gated.sv
`timescale 1ns/1ps
module test_clkdiv_gated;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic       wr    [2];
  logic [1:0] addr  [2];
  logic [7:0] wdata [2];
  logic [7:0] rdata [2];
  logic       cko   [2];
  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  clkdiv_gated #(.DATA_W(8), .WIDE_MODE(1'b0), .GATE_BIT(0)) i_clkdiv_gated (
    .clk_ref(clk), .rst_n(rst_n), .reg_wr(wr[0]), .reg_addr(addr[0]),
    .reg_wdata(wdata[0]), .reg_rdata(rdata[0]), .clk_div_o(cko[0]));

  clkdiv_gated #(.DATA_W(8), .WIDE_MODE(1'b1), .GATE_BIT(0)) i_clkdiv_gated_wide (
    .clk_ref(clk), .rst_n(rst_n), .reg_wr(wr[1]), .reg_addr(addr[1]),
    .reg_wdata(wdata[1]), .reg_rdata(rdata[1]), .clk_div_o(cko[1]));

  // {instance, code, expected period}
  localparam logic [23:0] VEC [0:11] = '{
    {4'd0, 8'h04, 12'd4},   {4'd0, 8'h05, 12'd5},   {4'd0, 8'h00, 12'd32},
    {4'd0, 8'h1F, 12'd31},  {4'd0, 8'h02, 12'd2},   {4'd0, 8'h03, 12'd3},
    {4'd1, 8'h00, 12'd64},  {4'd1, 8'h23, 12'd192}, {4'd1, 8'h20, 12'd64},
    {4'd1, 8'h1F, 12'd31},  {4'd1, 8'h21, 12'd64},  {4'd1, 8'h3F, 12'd1984}
  };

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic reg_write(input int s, input logic [1:0] a, input logic [7:0] d);
    wr[s] = 1'b1; addr[s] = a; wdata[s] = d;
    tick();
    wr[s] = 1'b0;
  endtask

  task automatic reg_read(input int s, input logic [1:0] a, output logic [7:0] v);
    addr[s] = a;
    #1;
    v = rdata[s];
  endtask

  task automatic busy_len(input int s, output int n);
    logic [7:0] v;
    n = 0;
    reg_read(s, 2'd0, v);
    while (v != 8'h00 && n < 5000) begin
      n++;
      tick();
      reg_read(s, 2'd0, v);
    end
  endtask

  task automatic measure(input int s, output int hi, output int lo);
    int g = 0;
    hi = 0; lo = 0;
    while (cko[s] !== 1'b0 && g < 6000) begin tick(); g++; end
    while (cko[s] !== 1'b1 && g < 6000) begin tick(); g++; end
    while (cko[s] === 1'b1 && g < 6000) begin hi++; tick(); g++; end
    while (cko[s] === 1'b0 && g < 6000) begin lo++; tick(); g++; end
  endtask

  initial begin
    #(150000 * 5);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int n, hi, lo;
    for (int s = 0; s < 2; s++) begin
      wr[s] = 1'b0; addr[s] = 2'd0; wdata[s] = 8'h00;
    end
    repeat (4) tick();
    rst_n = 1'b1;
    repeat (4) tick();

    // R1: reset state of both instances
    for (int s = 0; s < 2; s++) begin
      reg_read(s, 2'd0, v); check(v == 8'h00, "R1 status reset", v, 0);
      reg_read(s, 2'd1, v); check(v == 8'h00, "R1 enable reset", v, 0);
      reg_read(s, 2'd2, v); check(v == 8'h00, "R1 divisor reset", v, 0);
      check(cko[s] == 1'b0, "R1 output low at reset", cko[s], 0);
    end

    // R7: busy length with the output stopped, bits 3 and 4 both set
    reg_write(0, 2'd2, 8'h04);
    reg_read(0, 2'd0, v);
    check(v == 8'h18, "R7 busy bits after write", v, 8'h18);
    busy_len(0, n);
    check(n == 3, "R7 busy cycles while stopped", n, 3);

    // R1: enable register keeps only its gate bit
    for (int s = 0; s < 2; s++) begin
      reg_write(s, 2'd1, 8'hFF);
      reg_read(s, 2'd1, v);
      check(v == 8'h01, "R1 enable readback", v, 1);
    end

    // R2 R3 R4 R5: table of codes
    for (int i = 0; i < 12; i++) begin
      int s, per;
      logic [7:0] c;
      string tag;
      s   = int'(VEC[i][23:20]);
      c   = VEC[i][19:12];
      per = int'(VEC[i][11:0]);
      if (c[4:0] == 5'd0 && !c[5]) tag = "R3";
      else if (s == 1 && c[5])     tag = "R4";
      else                         tag = "R2";
      reg_write(s, 2'd2, c);
      busy_len(s, n);
      measure(s, hi, lo);
      check(hi + lo == per, {tag, " period"}, hi + lo, per);
      check(hi == per / 2, "R5 high phase", hi, per / 2);
    end

    // R7 R8: busy while running spans to the boundary plus 2
    reg_write(0, 2'd2, 8'h00);
    busy_len(0, n);
    measure(0, hi, lo);
    reg_write(0, 2'd2, 8'h04);
    busy_len(0, n);
    check(n == 33, "R7 busy cycles while running", n, 33);
    measure(0, hi, lo);
    check(hi + lo == 4, "R8 new ratio after boundary", hi + lo, 4);

    // R10: back-to-back writes, last one wins
    reg_write(0, 2'd2, 8'h06);
    reg_write(0, 2'd2, 8'h0A);
    reg_read(0, 2'd2, v);
    check(v == 8'h0A, "R10 divisor readback", v, 10);
    busy_len(0, n);
    measure(0, hi, lo);
    check(hi + lo == 10, "R10 last code applied", hi + lo, 10);

    // R9: clearing the gate keeps the final high phase whole
    reg_write(0, 2'd2, 8'h00);
    busy_len(0, n);
    measure(0, hi, lo);
    hi = 1;
    reg_write(0, 2'd1, 8'h00);
    while (cko[0] === 1'b1 && hi < 100) begin hi++; tick(); end
    check(hi == 16, "R9 last high phase length", hi, 16);
    n = 0;
    for (int k = 0; k < 80; k++) begin
      if (cko[0] !== 1'b0) n++;
      tick();
    end
    check(n == 0, "R9 output stays low when gated", n, 0);

    // R6: ratio 1 passes the reference
    reg_write(0, 2'd2, 8'h01);
    busy_len(0, n);
    reg_write(0, 2'd1, 8'h01);
    repeat (3) tick();
    n = 0;
    for (int k = 0; k < 8; k++) begin
      tick();
      if (cko[0] !== 1'b1) n++;
      @(negedge clk); #1;
      if (cko[0] !== 1'b0) n++;
    end
    check(n == 0, "R6 pass-through mismatches", n, 0);
    reg_write(0, 2'd1, 8'h00);
    repeat (3) tick();
    check(cko[0] == 1'b0, "R6 R9 pass-through gated off", cko[0], 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule